// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block is a memory-mapped timer with one up-counter whose period is shared by eight PWM channels. Software picks the counter's tick source from three clock-enable strobes through an encoded field, in which code zero parks the counter. It also sets a power-of-two prescaler, a starting count and a terminal (modulo) count. Each channel compares the shared count against its own compare value to produce an edge-aligned, high-true waveform. Per-channel mask, polarity and stopped-state level registers shape what reaches the pins.

The modulo and compare registers are buffered. A running counter only picks up new values when it wraps, so a period in progress is never cut short. While the counter is parked, new values take effect at once and the count sits at the programmed starting value.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset, every register reads zero except the output mask at 0x60, which reads 0xFF. All pins are low. Each register reads back what was written, limited to its width.
- R2: Bits [4:3] of the control register at 0x00 pick the tick source: 0 parks the counter at the starting count (register 0x4C), 1 ticks on every clock, 2 ticks on `tickFixed` and 3 ticks on `tickExt`.
- R3: Bits [2:0] of the control register hold a prescaler code p. The counter advances once every 2^p selected ticks.
- R4: The counter, read at 0x04, steps from the starting count up to the modulo (0x08) and then reloads to the starting count, giving modulo − start + 1 counts per period. Writes to 0x04 are ignored.
- R5: Channel n has a control register at 0x0C+8n and a compare register at 0x10+8n. When control bits 5 and 3 are both set, the channel is active while count < compare, so with a starting count of 0 it is active for compare counts from each reload. Any other setting keeps the channel inactive.
- R6: A compare of zero keeps the channel inactive for the whole period. A compare above the modulo keeps it active for the whole period.
- R7: While running, writes to the modulo and compare registers take effect only at the next reload. While parked, they take effect at once.
- R8: A set bit in the mask register (0x60, bit n for channel n) drives that pin to its inactive level.
- R9: A set bit in the polarity register (0x70) makes that channel active-low, so the pin is the inverse of the channel level.
- R10: While the counter is parked, each channel's level is the matching bit of the stopped-level register (0x5C), before mask and polarity are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickFixed | input | 1 | Fixed-rate clock-enable strobe |
| tickExt | input | 1 | External clock-enable strobe |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write enable, one write per cycle |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | 8 | PWM pins, one per channel |

## Verification
A corrupted count, prescaler phase or working copy changes the counter readback and the pin pattern within one advance of the counter, which is one clock at the fastest setting. A shadow value loaded at the wrong moment shows up as a shortened or stretched period, visible at the first wrap after the write. The reference model is stepped every clock and compared against both the pins and the readback, so a fault is caught at the clock where it first reaches a port, not only at the end of a measurement window.

// File: rtl/shared_pwm_pkg.sv
package shared_pwm_pkg;
  // strobes from the register/prescale control to the counting datapath
  typedef struct packed {
    logic advance;  // counter moves one step this cycle
    logic hold;     // counter parked: keep at start count, copy shadows
  } pwm_strobe_t;

  localparam logic [7:0] ADDR_CTRL  = 8'h00;
  localparam logic [7:0] ADDR_COUNT = 8'h04;
  localparam logic [7:0] ADDR_MOD   = 8'h08;
  localparam logic [7:0] ADDR_CHAN  = 8'h0C;
  localparam logic [7:0] ADDR_START = 8'h4C;
  localparam logic [7:0] ADDR_OINIT = 8'h5C;
  localparam logic [7:0] ADDR_MASK  = 8'h60;
  localparam logic [7:0] ADDR_POL   = 8'h70;
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import shared_pwm_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = 16,
  parameter int PSW  = 3,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickFixed,
  input  logic                      tickExt,
  input  logic [AW-1:0]             busAddr,
  input  logic [DW-1:0]             busWdata,
  input  logic                      busWe,
  input  logic [CW-1:0]             cntVal,
  output pwm_strobe_t               strb,
  output logic [CW-1:0]             modShadow,
  output logic [CW-1:0]             startVal,
  output logic [N_CH-1:0][CW-1:0]   cmpShadow,
  output logic [N_CH-1:0]           chanPwmEn,
  output logic [N_CH-1:0]           outInit,
  output logic [N_CH-1:0]           outMask,
  output logic [N_CH-1:0]           outPol,
  output logic [DW-1:0]             busRdata
);
  localparam int PSCW   = (1 << PSW) - 1;
  localparam int STRIDE = 8;

  logic [PSW-1:0]            psCode;
  logic [1:0]                clkSel;
  logic [N_CH-1:0][3:0]      chanCtrl;
  logic [PSCW-1:0]           psCnt;
  logic [PSCW-1:0]           psLimit;
  logic                      tickSel;

  always_comb begin
    unique case (clkSel)
      2'd1:    tickSel = 1'b1;
      2'd2:    tickSel = tickFixed;
      2'd3:    tickSel = tickExt;
      default: tickSel = 1'b0;
    endcase
  end

  assign psLimit      = PSCW'((32'd1 << psCode) - 32'd1);
  assign strb.hold    = (clkSel == 2'd0);
  assign strb.advance = tickSel && (psCnt >= psLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             psCnt <= '0;
    else if (strb.hold)    psCnt <= '0;
    else if (tickSel)      psCnt <= (psCnt >= psLimit) ? '0 : psCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCode    <= '0;
      clkSel    <= '0;
      modShadow <= '0;
      startVal  <= '0;
      outInit   <= '0;
      outMask   <= '1;
      outPol    <= '0;
      chanCtrl  <= '0;
      cmpShadow <= '0;
    end else if (busWe) begin
      case (busAddr)
        ADDR_CTRL:  begin psCode <= busWdata[PSW-1:0]; clkSel <= busWdata[PSW+1:PSW]; end
        ADDR_MOD:   modShadow <= busWdata[CW-1:0];
        ADDR_START: startVal  <= busWdata[CW-1:0];
        ADDR_OINIT: outInit   <= busWdata[N_CH-1:0];
        ADDR_MASK:  outMask   <= busWdata[N_CH-1:0];
        ADDR_POL:   outPol    <= busWdata[N_CH-1:0];
        default: ;
      endcase
      for (int i = 0; i < N_CH; i++) begin
        if (busAddr == AW'(ADDR_CHAN + STRIDE * i))     chanCtrl[i]  <= busWdata[5:2];
        if (busAddr == AW'(ADDR_CHAN + 4 + STRIDE * i)) cmpShadow[i] <= busWdata[CW-1:0];
      end
    end
  end

  // edge-aligned high-true needs mode-select B and level-select B
  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_en
      assign chanPwmEn[g] = chanCtrl[g][3] && chanCtrl[g][1];
    end
  endgenerate

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL:  busRdata = DW'({clkSel, psCode});
      ADDR_COUNT: busRdata = DW'(cntVal);
      ADDR_MOD:   busRdata = DW'(modShadow);
      ADDR_START: busRdata = DW'(startVal);
      ADDR_OINIT: busRdata = DW'(outInit);
      ADDR_MASK:  busRdata = DW'(outMask);
      ADDR_POL:   busRdata = DW'(outPol);
      default: ;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (busAddr == AW'(ADDR_CHAN + STRIDE * i))     busRdata = DW'({chanCtrl[i], 2'b00});
      if (busAddr == AW'(ADDR_CHAN + 4 + STRIDE * i)) busRdata = DW'(cmpShadow[i]);
    end
  end

  // R2
  clk_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 2'd0) |-> !strb.advance);

  // R3
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && psCode != '0 && !busWe) |=> !strb.advance);
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import shared_pwm_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pwm_strobe_t               strb,
  input  logic [CW-1:0]             modShadow,
  input  logic [CW-1:0]             startVal,
  input  logic [N_CH-1:0][CW-1:0]   cmpShadow,
  input  logic [N_CH-1:0]           chanPwmEn,
  input  logic [N_CH-1:0]           outInit,
  input  logic [N_CH-1:0]           outMask,
  input  logic [N_CH-1:0]           outPol,
  output logic [CW-1:0]             cntVal,
  output logic [N_CH-1:0]           pwmOut
);
  logic [CW-1:0]           modWork;
  logic [N_CH-1:0][CW-1:0] cmpWork;
  logic                    atTop;

  assign atTop = (cntVal >= modWork);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= '0;
      modWork <= '0;
      cmpWork <= '0;
    end else if (strb.hold || (strb.advance && atTop)) begin
      cntVal  <= startVal;
      modWork <= modShadow;
      cmpWork <= cmpShadow;
    end else if (strb.advance) begin
      cntVal  <= cntVal + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic level;
      assign level     = strb.hold ? outInit[g] : (chanPwmEn[g] && (cntVal < cmpWork[g]));
      assign pwmOut[g] = outMask[g] ? outPol[g] : (level ^ outPol[g]);

      // R8
      mask_level_chk: assert property (@(posedge clk) disable iff (!rstN)
        outMask[g] |-> (pwmOut[g] == outPol[g]));
    end
  endgenerate

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.hold) |=> $stable(cntVal));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.hold && !atTop) |=> (cntVal == $past(cntVal) + 1'b1));
endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
  import shared_pwm_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = 16,
  parameter int PSW  = 3,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tickFixed,
  input  logic            tickExt,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW-1:0]   busWdata,
  input  logic            busWe,
  output logic [DW-1:0]   busRdata,
  output logic [N_CH-1:0] pwmOut
);
  pwm_strobe_t             strb;
  logic [CW-1:0]           cntVal, modShadow, startVal;
  logic [N_CH-1:0][CW-1:0] cmpShadow;
  logic [N_CH-1:0]         chanPwmEn, outInit, outMask, outPol;

  pwm_ctrl_regs #(.N_CH(N_CH), .CW(CW), .PSW(PSW), .AW(AW), .DW(DW)) uRegs (
    .clk(clk), .rstN(rstN), .tickFixed(tickFixed), .tickExt(tickExt),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .cntVal(cntVal),
    .strb(strb), .modShadow(modShadow), .startVal(startVal), .cmpShadow(cmpShadow),
    .chanPwmEn(chanPwmEn), .outInit(outInit), .outMask(outMask), .outPol(outPol),
    .busRdata(busRdata)
  );

  pwm_core #(.N_CH(N_CH), .CW(CW)) uCore (
    .clk(clk), .rstN(rstN), .strb(strb), .modShadow(modShadow), .startVal(startVal),
    .cmpShadow(cmpShadow), .chanPwmEn(chanPwmEn), .outInit(outInit), .outMask(outMask),
    .outPol(outPol), .cntVal(cntVal), .pwmOut(pwmOut)
  );
endmodule

// File: tb/shared_pwm_timer_test.sv
module shared_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickFixed = 1'b0, tickExt = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic [7:0]  pwmOut;

  int total = 0, bad = 0, cyc = 0, tc = 0;
  bit done = 0;

  shared_pwm_timer uut (.clk(clk), .rstN(rstN), .tickFixed(tickFixed), .tickExt(tickExt),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata), .pwmOut(pwmOut));

  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mPs, mClk, mMod, mStart, mOinit, mMask, mPol, mPsc, mCnt, mModW;
  int mCtl[8], mCmpS[8], mCmpW[8];
  int lim; bit tck, adv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPs = 0; mClk = 0; mMod = 0; mStart = 0; mOinit = 0; mMask = 'hFF; mPol = 0;
      mPsc = 0; mCnt = 0; mModW = 0;
      for (int i = 0; i < 8; i++) begin mCtl[i] = 0; mCmpS[i] = 0; mCmpW[i] = 0; end
    end else begin
      tck = (mClk == 1) || (mClk == 2 && tickFixed) || (mClk == 3 && tickExt);
      lim = (1 << mPs) - 1;
      adv = tck && (mPsc >= lim);
      if (mClk == 0 || (adv && mCnt >= mModW)) begin
        mCnt = mStart; mModW = mMod;
        for (int i = 0; i < 8; i++) mCmpW[i] = mCmpS[i];
      end else if (adv) mCnt = (mCnt + 1) & 'hFFFF;
      if (mClk == 0) mPsc = 0;
      else if (tck) mPsc = (mPsc >= lim) ? 0 : mPsc + 1;
      if (busWe) begin
        case (busAddr)
          8'h00: begin mPs = busWdata[2:0]; mClk = busWdata[4:3]; end
          8'h08: mMod = busWdata[15:0];
          8'h4C: mStart = busWdata[15:0];
          8'h5C: mOinit = busWdata[7:0];
          8'h60: mMask = busWdata[7:0];
          8'h70: mPol = busWdata[7:0];
          default: ;
        endcase
        for (int i = 0; i < 8; i++) begin
          if (busAddr == 8'h0C + 8 * i) mCtl[i] = busWdata[5:2];
          if (busAddr == 8'h10 + 8 * i) mCmpS[i] = busWdata[15:0];
        end
      end
    end
  end

  function automatic logic [7:0] expPins();
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      bit lvl, en;
      en  = ((mCtl[i] >> 3) & 1) && ((mCtl[i] >> 1) & 1);
      lvl = (mClk == 0) ? ((mOinit >> i) & 1) : (en && mCnt < mCmpW[i]);
      p[i] = ((mMask >> i) & 1) ? ((mPol >> i) & 1) : (lvl ^ ((mPol >> i) & 1));
    end
    return p;
  endfunction

  function automatic int expRd(input int a);
    int r = 0;
    case (a)
      'h00: r = (mClk << 3) | mPs;
      'h04: r = mCnt;
      'h08: r = mMod;
      'h4C: r = mStart;
      'h5C: r = mOinit;
      'h60: r = mMask;
      'h70: r = mPol;
      default: ;
    endcase
    for (int i = 0; i < 8; i++) begin
      if (a == 'h0C + 8 * i) r = mCtl[i] << 2;
      if (a == 'h10 + 8 * i) r = mCmpS[i];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) chk(pwmOut == 8'h00, "R1 pins low in reset", pwmOut, 0);
      else begin
        chk(pwmOut == expPins(), "R5 per-clock pin compare", pwmOut, expPins());
        chk(busRdata == 32'(expRd(busAddr)), "R4 per-clock readback compare", busRdata, expRd(busAddr));
      end
    end
  end

  always @(negedge clk) begin
    #1; tc++;
    tickFixed = (tc % 3 == 0);
    tickExt   = (tc % 5 == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      chk(0, "watchdog expired", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // -------- stimulus helpers: enter and leave just after a falling edge --------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); #1; busWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expectRead(input logic [7:0] a, input int exp, input string tag);
    busAddr = a;
    @(negedge clk);
    chk(busRdata == 32'(exp), tag, busRdata, exp);
    #1;
  endtask

  task automatic countHigh(input int n, input int ch, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += pwmOut[ch]; end
    #1;
  endtask

  task automatic countChanges(input int n, output int c);
    logic [31:0] prev;
    busAddr = 8'h04; c = 0;
    @(negedge clk); prev = busRdata;
    repeat (n) begin
      @(negedge clk);
      if (busRdata != prev) c++;
      prev = busRdata;
    end
    #1;
  endtask

  initial begin
    int h, c;
    bit seen;
    idle(4);
    rstN = 1'b1;
    idle(1);
    expectRead(8'h60, 'hFF, "R1 mask resets to all ones");
    expectRead(8'h00, 0, "R1 control resets to zero");
    expectRead(8'h08, 0, "R1 modulo resets to zero");
    expectRead(8'h04, 0, "R1 counter resets to zero");

    // period 4 counts, ch0 duty 2, ch1 compare 0, ch2 compare above modulo, ch3 wrong mode
    wr(8'h4C, 0); wr(8'h08, 3);
    wr(8'h0C, 'h28); wr(8'h10, 2);
    wr(8'h14, 'h28); wr(8'h18, 0);
    wr(8'h1C, 'h28); wr(8'h20, 9);
    wr(8'h24, 'h10); wr(8'h28, 2);
    wr(8'h70, 0); wr(8'h60, 0);
    wr(8'h00, 'h08);
    idle(8);
    countHigh(40, 0, h); chk(h == 20, "R5 half duty on ch0", h, 20);
    countHigh(40, 1, h); chk(h == 0, "R6 zero compare stays inactive", h, 0);
    countHigh(40, 2, h); chk(h == 40, "R6 compare above modulo stays active", h, 40);
    countHigh(40, 3, h); chk(h == 0, "R5 non-PWM mode stays inactive", h, 0);
    countChanges(48, c); chk(c == 48, "R2 system clock ticks every cycle", c, 48);

    wr(8'h00, 'h0A); idle(20);
    countChanges(48, c); chk(c == 12, "R3 prescale code 2 divides by 4", c, 12);
    wr(8'h00, 'h10); idle(20);
    countChanges(48, c); chk(c == 16, "R2 fixed tick source", c, 16);
    wr(8'h00, 'h18); idle(20);
    countChanges(60, c); chk(c == 12, "R2 external tick source", c, 12);

    // R7: modulo written mid-period applies only after the current wrap
    wr(8'h00, 'h08); idle(8);
    busAddr = 8'h04;
    do @(negedge clk); while (busRdata != 1);
    #1; wr(8'h08, 7); busAddr = 8'h04;
    do @(negedge clk); while (busRdata != 3);
    @(negedge clk);
    chk(busRdata == 0, "R7 old modulo kept until wrap", busRdata, 0);
    seen = 0;
    repeat (12) begin @(negedge clk); if (busRdata == 7) seen = 1; end
    #1;
    chk(seen, "R7 new modulo used after wrap", seen, 1);

    // R8 / R9 with period 8 counts
    idle(8);
    wr(8'h70, 'h01); wr(8'h60, 'h01); idle(2);
    countHigh(32, 0, h); chk(h == 32, "R8 masked inverted pin sits high", h, 32);
    countHigh(32, 2, h); chk(h == 32, "R8 unmasked full duty pin", h, 32);
    wr(8'h60, 0); wr(8'h70, 'h05); idle(8);
    countHigh(32, 0, h); chk(h == 24, "R9 inverted duty on ch0", h, 24);
    countHigh(32, 2, h); chk(h == 0, "R9 inverted full duty", h, 0);

    // R10 and parked counter
    wr(8'h70, 0); wr(8'h5C, 'h02); wr(8'h4C, 2); wr(8'h00, 0); idle(3);
    countHigh(16, 1, h); chk(h == 16, "R10 stopped level drives ch1 high", h, 16);
    countHigh(16, 0, h); chk(h == 0, "R10 stopped level keeps ch0 low", h, 0);
    expectRead(8'h04, 2, "R2 parked counter holds start count");
    wr(8'h04, 'h55);
    expectRead(8'h04, 2, "R4 counter write ignored");

    wr(8'h44, 'hFF);
    expectRead(8'h44, 'h3C, "R1 channel control width");
    wr(8'h48, 'h1234);
    expectRead(8'h48, 'h1234, "R1 channel 7 compare readback");
    expectRead(8'h5C, 'h02, "R1 stopped-level readback");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule